// File: doc/BRIEF.md
# Banked Cartridge Controller with Snapshot Calendar

This block translates CPU addresses into physical ROM and RAM addresses for a banked cartridge. It also holds a small calendar counter of seconds, minutes, hours and a 9-bit day count. Software programs it by writing into the read-only code space. Each write group sets one piece of state: the RAM enable, the switchable ROM bank, the RAM bank or calendar selector, and the snapshot control.

When a calendar register is selected, the external RAM window at 0xA000–0xBFFF stops reaching RAM. Writes there load the selected live counter. Reads return a frozen copy of that counter. Software takes the copy by writing 0x00 and then 0x01 to the snapshot group, so a multi-byte time value is read consistently while the counters keep running. The counters advance on a one-cycle `tick` pulse, normally one per second. A halt bit in the control register stops them.

Top module: `rtc_bank_ctrl`

## Requirements
- R1: A write to 0x2000–0x3FFF loads the ROM bank from data bits 6:0, and a value of 0 is stored as 1. For addresses 0x4000–0x7FFF, `rom_phys` is {bank, addr[13:0]}. For 0x0000–0x3FFF, `rom_phys` is {0, addr[13:0]}.
- R2: A write to 0x0000–0x1FFF enables the RAM window when data bits 3 and 1 are both set, and disables it otherwise.
- R3: A write to 0x4000–0x5FFF with a value below 8 selects that RAM bank and returns the window to RAM mode. `ram_phys` is {bank, addr[12:0]}.
- R4: A write to 0x4000–0x5FFF with a value of 8 or more stores that value as the calendar selector and puts the window in calendar mode, but only while RAM is enabled. While RAM is disabled, such a write changes nothing.
- R5: `ram_we` is 1 only for a bus write into 0xA000–0xBFFF while RAM is enabled and in RAM mode. In calendar mode with RAM enabled, such a write loads a live register chosen by the selector: 0x08 seconds, 0x09 minutes, 0x0A hours, 0x0B day bits 7:0, 0x0C control. Any other selector value has no effect.
- R6: The control byte layout is: bit 0 = day bit 8, bits 5:1 = free storage, bit 6 = halt, bit 7 = sticky day carry. A control write stores bits 6:0 as written. Bit 7 is set if data bit 7 is set or if it was already set.
- R7: On a cycle with `tick` high, halt clear and no calendar write, the counters advance. Seconds go from 59 to 0 with a carry, and any other value increments by one. Minutes behave the same on a carry (59 wraps). Hours wrap at 23. The day count wraps from 511 to 0 and sets the sticky carry. A calendar write in the same cycle drops the tick.
- R8: While halt is set, ticks leave all counters unchanged.
- R9: A write of 0x01 to 0x6000–0x7FFF while the stored snapshot state is 0 copies all five live registers into the snapshot. Only data values 0x00 and 0x01 update the stored state; other values leave it unchanged.
- R10: `win_use_ram` is 1 when RAM is enabled and in RAM mode. `win_rdata` is the snapshot value of the selected register when RAM is enabled and in calendar mode. It is 0 for an undefined selector, and 0 when RAM is disabled or in RAM mode.
- R11: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, RAM mode is selected, and all counters, snapshots and the stored snapshot state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| tick | input | 1 | One-cycle pulse per calendar second |
| rom_phys | output | 21 | Physical ROM address |
| ram_phys | output | 16 | Physical RAM address |
| ram_we | output | 1 | External RAM write enable |
| win_use_ram | output | 1 | External RAM supplies window read data |
| win_rdata | output | 8 | Window read data when RAM does not supply it |

## Verification
The assertions check these properties on every cycle:
- the switchable ROM bank never maps to zero;
- a RAM write happens only in RAM mode;
- a disabled window reads zero;
- seconds hold while halted and step by one on a plain tick;
- a snapshot captures the value seconds had on the cycle before.

Only the bench scenarios can show the full cascade from 23:59:59 on day 511 into the sticky carry, and that the carry survives a control write of zero. They also show that repeated 0x01 writes or stray values in the snapshot group take no new copy, and that a calendar write in a tick cycle drops the tick.

// File: rtl/rtc_bank_pkg.sv
// Shared types and constants for the banked controller with calendar.
// Assumes the selector codes and control-bit positions below are fixed
// by the software interface.
package rtc_bank_pkg;
    localparam logic [7:0] SEL_SEC  = 8'h08;
    localparam logic [7:0] SEL_MIN  = 8'h09;
    localparam logic [7:0] SEL_HOUR = 8'h0A;
    localparam logic [7:0] SEL_DAY  = 8'h0B;
    localparam logic [7:0] SEL_CTRL = 8'h0C;

    localparam logic [7:0] SEC_LAST  = 8'd59;
    localparam logic [7:0] MIN_LAST  = 8'd59;
    localparam logic [7:0] HOUR_LAST = 8'd23;
    localparam logic [8:0] DAY_LAST  = 9'd511;

    // Write groups decoded from addr[14:13] of the code space
    typedef enum logic [1:0] {
        GRP_ENABLE = 2'b00,
        GRP_ROMSEL = 2'b01,
        GRP_RAMSEL = 2'b10,
        GRP_SNAP   = 2'b11
    } wr_grp_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [8:0] day;
        logic       carry;
        logic       halt;
        logic [4:0] spare;
    } cal_t;

    // Pack the control byte: carry, halt, spare, day bit 8
    function automatic logic [7:0] ctrl_byte(input cal_t t);
        return {t.carry, t.halt, t.spare, t.day[8]};
    endfunction
endpackage

// File: rtl/rtc_bank_regs.sv
// Bank and mode registers written through the code-space write groups.
// Assumes wr_ok is a single-cycle strobe qualified to addr[15] == 0.
module rtc_bank_regs
    import rtc_bank_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ok,
    input  wr_grp_e               grp,
    input  logic [7:0]            data,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en,
    output logic                  cal_mode,
    output logic [7:0]            cal_sel
);
    localparam int RAM_BANKS = 1 << RAM_BANK_W;

    logic [ROM_BANK_W-1:0] rom_req;
    logic                  below_banks;

    // ROM request with zero remapped to one
    always_comb begin
        rom_req = data[ROM_BANK_W-1:0];
        if (rom_req == '0) rom_req = ROM_BANK_W'(1);
    end

    // Data value small enough to be a RAM bank number
    assign below_banks = (32'(data) < RAM_BANKS);

    // Register updates per write group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
            ram_en   <= 1'b0;
            cal_mode <= 1'b0;
            cal_sel  <= '0;
        end else if (wr_ok) begin
            case (grp)
                GRP_ENABLE: ram_en <= data[3] & data[1];
                GRP_ROMSEL: rom_bank <= rom_req;
                GRP_RAMSEL: begin
                    if (below_banks) begin
                        ram_bank <= data[RAM_BANK_W-1:0];
                        cal_mode <= 1'b0;
                    end else if (ram_en) begin
                        cal_mode <= 1'b1;
                        cal_sel  <= data;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc_cal_core.sv
// Live calendar counters: cascaded tick advance and register loads.
// Assumes tick is a one-cycle pulse; a register load drops a same-cycle tick.
module rtc_cal_core
    import rtc_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic [7:0] sel,
    input  logic [7:0] data,
    output cal_t       live
);
    cal_t nxt;

    // Next value after one tick, with cascaded carries
    always_comb begin
        nxt = live;
        if (live.sec == SEC_LAST) begin
            nxt.sec = '0;
            if (live.min == MIN_LAST) begin
                nxt.min = '0;
                if (live.hour == HOUR_LAST) begin
                    nxt.hour = '0;
                    if (live.day == DAY_LAST) begin
                        nxt.day   = '0;
                        nxt.carry = 1'b1;
                    end else begin
                        nxt.day = live.day + 9'd1;
                    end
                end else begin
                    nxt.hour = live.hour + 8'd1;
                end
            end else begin
                nxt.min = live.min + 8'd1;
            end
        end else begin
            nxt.sec = live.sec + 8'd1;
        end
    end

    // Live register state: load has priority, halt blocks ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_SEC:  live.sec <= data;
                SEL_MIN:  live.min <= data;
                SEL_HOUR: live.hour <= data;
                SEL_DAY:  live.day[7:0] <= data;
                SEL_CTRL: begin
                    live.day[8] <= data[0];
                    live.spare  <= data[5:1];
                    live.halt   <= data[6];
                    live.carry  <= live.carry | data[7];
                end
                default: ;
            endcase
        end else if (tick && !live.halt) begin
            live <= nxt;
        end
    end
endmodule

// File: rtl/rtc_snapshot.sv
// Snapshot of the live counters on a 0-then-1 write, plus the window read mux.
// Assumes snap_wr is a single-cycle strobe for the snapshot write group.
module rtc_snapshot
    import rtc_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snap_wr,
    input  logic [7:0] data,
    input  cal_t       live,
    input  logic [7:0] sel,
    input  logic       rd_cal,
    output cal_t       snap,
    output logic       snap_st,
    output logic [7:0] rdata
);
    // Stored state update and copy on the 0 -> 1 sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap    <= '0;
            snap_st <= 1'b0;
        end else if (snap_wr) begin
            if (data == 8'h01 && !snap_st) snap <= live;
            if (data == 8'h00 || data == 8'h01) snap_st <= data[0];
        end
    end

    // Window read data from the snapshot
    always_comb begin
        rdata = '0;
        if (rd_cal) begin
            case (sel)
                SEL_SEC:  rdata = snap.sec;
                SEL_MIN:  rdata = snap.min;
                SEL_HOUR: rdata = snap.hour;
                SEL_DAY:  rdata = snap.day[7:0];
                SEL_CTRL: rdata = ctrl_byte(snap);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_bank_ctrl.sv
// Top: decodes CPU writes, forms physical ROM/RAM addresses, and steers the
// external RAM window to RAM or to the calendar snapshot.
// Assumes one bus write per strobe cycle and a 16-bit CPU address space.
module rtc_bank_ctrl
    import rtc_bank_pkg::*;
#(
    parameter int ROM_BANK_W  = 7,
    parameter int RAM_BANK_W  = 3,
    parameter int ROM_PAGE_AW = 14,
    parameter int RAM_PAGE_AW = 13,
    localparam int ROM_AW     = ROM_BANK_W + ROM_PAGE_AW,
    localparam int RAM_AW     = RAM_BANK_W + RAM_PAGE_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              tick,
    output logic [ROM_AW-1:0] rom_phys,
    output logic [RAM_AW-1:0] ram_phys,
    output logic              ram_we,
    output logic              win_use_ram,
    output logic [7:0]        win_rdata
);
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_en;
    logic                  cal_mode;
    logic [7:0]            cal_sel;
    logic                  code_wr;
    logic                  in_win;
    logic                  cal_wr;
    logic                  snap_st;
    logic                  halt;
    logic [7:0]            live_sec;
    logic [7:0]            snap_sec;
    cal_t                  live;
    cal_t                  snap;
    wr_grp_e               grp;

    // Bus decode
    assign code_wr = bus_wr & ~bus_addr[15];
    assign grp     = wr_grp_e'(bus_addr[14:13]);
    assign in_win  = (bus_addr[15:13] == 3'b101);
    assign cal_wr  = bus_wr & in_win & ram_en & cal_mode;

    rtc_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(code_wr), .grp(grp), .data(bus_wdata),
        .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
        .cal_mode(cal_mode), .cal_sel(cal_sel)
    );

    rtc_cal_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(cal_wr),
        .sel(cal_sel), .data(bus_wdata), .live(live)
    );

    rtc_snapshot u_snap (
        .clk(clk), .rst_n(rst_n), .snap_wr(code_wr && grp == GRP_SNAP),
        .data(bus_wdata), .live(live), .sel(cal_sel),
        .rd_cal(ram_en & cal_mode), .snap(snap), .snap_st(snap_st),
        .rdata(win_rdata)
    );

    // Physical address formation
    always_comb begin
        rom_phys = {{ROM_BANK_W{1'b0}}, bus_addr[ROM_PAGE_AW-1:0]};
        if (bus_addr[14]) rom_phys = {rom_bank, bus_addr[ROM_PAGE_AW-1:0]};
        ram_phys = {ram_bank, bus_addr[RAM_PAGE_AW-1:0]};
    end

    // Window steering
    assign ram_we      = bus_wr & in_win & ram_en & ~cal_mode;
    assign win_use_ram = ram_en & ~cal_mode;

    // Probes for the bound checker
    assign halt     = live.halt;
    assign live_sec = live.sec;
    assign snap_sec = snap.sec;
endmodule

// File: rtl/rtc_bank_ctrl_chk.sv
// Property checker for rtc_bank_ctrl, attached by bind below.
// Assumes the probe signals named in the bind exist in the top.
module rtc_bank_ctrl_chk #(
    parameter int ROM_AW      = 21,
    parameter int ROM_PAGE_AW = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [15:0]       bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              tick,
    input logic [ROM_AW-1:0] rom_phys,
    input logic              ram_we,
    input logic              win_use_ram,
    input logic [7:0]        win_rdata,
    input logic              ram_en,
    input logic              halt,
    input logic              snap_st,
    input logic [7:0]        live_sec,
    input logic [7:0]        snap_sec
);
    logic win_wr;
    assign win_wr = bus_wr && bus_addr[15:13] == 3'b101;

    // R1
    rom_bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[15:14] == 2'b01 |-> rom_phys[ROM_AW-1:ROM_PAGE_AW] != '0);

    // R2
    ram_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:13] == 3'b000 && bus_wdata[3] && bus_wdata[1]) |=> ram_en);

    // R5
    ram_we_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> win_use_ram);

    // R10
    disabled_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> (win_rdata == 8'h00 && !win_use_ram));

    // R7
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !win_wr && live_sec != 8'd59) |=> live_sec == $past(live_sec) + 8'd1);

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !win_wr) |=> $stable(live_sec));

    // R9
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:13] == 3'b011 && bus_wdata == 8'h01 && !snap_st)
        |=> snap_sec == $past(live_sec));
endmodule

bind rtc_bank_ctrl rtc_bank_ctrl_chk #(.ROM_AW(ROM_AW), .ROM_PAGE_AW(ROM_PAGE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tick(tick), .rom_phys(rom_phys), .ram_we(ram_we),
    .win_use_ram(win_use_ram), .win_rdata(win_rdata), .ram_en(ram_en),
    .halt(halt), .snap_st(snap_st), .live_sec(live_sec), .snap_sec(snap_sec)
);

// File: tb/rtc_bank_ctrl_bench.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed scenarios with hand-computed expectations.
module rtc_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        tick = 1'b0;
    logic [20:0] rom_phys;
    logic [15:0] ram_phys;
    logic        ram_we;
    logic        win_use_ram;
    logic [7:0]  win_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rtc_bank_ctrl u_rtc_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tick(tick), .rom_phys(rom_phys),
        .ram_phys(ram_phys), .ram_we(ram_we), .win_use_ram(win_use_ram),
        .win_rdata(win_rdata)
    );

    // Reference model state
    int m_rom, m_ram, m_en, m_cal, m_sel, m_st;
    int m_sec, m_min, m_hr, m_day, m_car, m_halt, m_spare;
    int s_sec, s_min, s_hr, s_day, s_ctrl;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_rom = 1; m_ram = 0; m_en = 0; m_cal = 0; m_sel = 0; m_st = 0;
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_car = 0; m_halt = 0; m_spare = 0;
            s_sec = 0; s_min = 0; s_hr = 0; s_day = 0; s_ctrl = 0;
        end else begin
            int a, d;
            bit calw;
            a = bus_addr; d = bus_wdata;
            calw = bus_wr && a >= 'hA000 && a < 'hC000 && m_en != 0 && m_cal != 0;
            if (bus_wr && a < 'h8000) begin
                if (a < 'h2000) m_en = ((d & 'h0A) == 'h0A);
                else if (a < 'h4000) m_rom = ((d & 'h7F) == 0) ? 1 : (d & 'h7F);
                else if (a < 'h6000) begin
                    if (d < 8) begin m_ram = d; m_cal = 0; end
                    else if (m_en != 0) begin m_cal = 1; m_sel = d; end
                end else begin
                    if (d == 1 && m_st == 0) begin
                        s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_day = m_day % 256;
                        s_ctrl = m_car * 128 + m_halt * 64 + m_spare * 2 + m_day / 256;
                    end
                    if (d == 0 || d == 1) m_st = d;
                end
            end
            if (calw) begin
                case (m_sel)
                    'h08: m_sec = d;
                    'h09: m_min = d;
                    'h0A: m_hr = d;
                    'h0B: m_day = (m_day / 256) * 256 + d;
                    'h0C: begin
                        m_day = (m_day % 256) + (d % 2) * 256;
                        m_spare = (d / 2) % 32; m_halt = (d / 64) % 2;
                        if (d >= 128) m_car = 1;
                    end
                    default: ;
                endcase
            end else if (tick && m_halt == 0) begin
                if (m_sec == 59) begin
                    m_sec = 0;
                    if (m_min == 59) begin
                        m_min = 0;
                        if (m_hr == 23) begin
                            m_hr = 0;
                            if (m_day == 511) begin m_day = 0; m_car = 1; end
                            else m_day = m_day + 1;
                        end else m_hr = m_hr + 1;
                    end else m_min = m_min + 1;
                end else m_sec = (m_sec + 1) % 256;
            end
        end
    end

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int a, erd;
            a = bus_addr;
            check("R1", rom_phys, (a & 'h4000) ? m_rom * 16384 + (a % 16384) : (a % 16384));
            check("R3", ram_phys, m_ram * 8192 + (a % 8192));
            check("R5", ram_we, (bus_wr && a >= 'hA000 && a < 'hC000 && m_en != 0 && m_cal == 0) ? 1 : 0);
            check("R10", win_use_ram, (m_en != 0 && m_cal == 0) ? 1 : 0);
            erd = 0;
            if (m_en != 0 && m_cal != 0) begin
                case (m_sel)
                    'h08: erd = s_sec;
                    'h09: erd = s_min;
                    'h0A: erd = s_hr;
                    'h0B: erd = s_day;
                    'h0C: erd = s_ctrl;
                    default: erd = 0;
                endcase
            end
            check("R10", win_rdata, erd);
        end
    end

    // Stimulus helpers; each starts and ends 1 ns after a rising edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    task automatic snap_take();
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
    endtask

    task automatic cal_set(input logic [7:0] sel, input logic [7:0] v);
        wr(16'h4000, sel);
        wr(16'hA000, v);
    endtask

    task automatic cal_expect(string req, input logic [7:0] sel, input int exp);
        wr(16'h4000, sel);
        bus_addr = 16'hA000; #1;
        check(req, win_rdata, exp);
        @(posedge clk); #1;
    endtask

    // Watchdog
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R11: reset state
        bus_addr = 16'h4000; #1;
        check("R11", rom_phys, 21'h004000);
        check("R11", win_use_ram, 0);
        check("R11", win_rdata, 0);
        @(posedge clk); #1;

        // R1: zero maps to one, full bank width
        wr(16'h2100, 8'h00);
        bus_addr = 16'h4123; #1; check("R1", rom_phys, 21'h004123); @(posedge clk); #1;
        wr(16'h3FFF, 8'hFF);
        bus_addr = 16'h4123; #1; check("R1", rom_phys, (21'h7F << 14) | 21'h0123);
        bus_addr = 16'h0123; #1; check("R1", rom_phys, 21'h000123); @(posedge clk); #1;

        // R2: enable decode
        wr(16'h0000, 8'h0A); #1; check("R2", win_use_ram, 1); @(posedge clk); #1;
        wr(16'h1000, 8'h08); #1; check("R2", win_use_ram, 0); @(posedge clk); #1;
        wr(16'h0000, 8'h0F); #1; check("R2", win_use_ram, 1); @(posedge clk); #1;

        // R3 and R5: bank select and RAM write strobe
        wr(16'h4000, 8'h05);
        bus_addr = 16'hA010; #1; check("R3", ram_phys, 16'hA010); @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 16'hB123; bus_wdata = 8'h55; #1;
        check("R5", ram_we, 1);
        @(posedge clk); #1; bus_wr = 1'b0;

        // R4: selector ignored while disabled
        wr(16'h4000, 8'h02);
        wr(16'h0000, 8'h00);
        wr(16'h4000, 8'h08);
        wr(16'h0000, 8'h0A);
        bus_addr = 16'hA000; #1;
        check("R4", win_use_ram, 1);
        check("R4", ram_phys, 16'h4000);
        @(posedge clk); #1;
        wr(16'h4000, 8'h08); #1; check("R4", win_use_ram, 0); @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 16'hA000; bus_wdata = 8'h11; #1;
        check("R5", ram_we, 0);
        @(posedge clk); #1; bus_wr = 1'b0;

        // R7: full cascade into the sticky carry
        cal_set(8'h08, 8'd59); cal_set(8'h09, 8'd59); cal_set(8'h0A, 8'd23);
        cal_set(8'h0B, 8'hFF); cal_set(8'h0C, 8'h01);
        snap_take();
        cal_expect("R9", 8'h0C, 8'h01);
        pulse_tick(1);
        snap_take();
        cal_expect("R7", 8'h08, 0);
        cal_expect("R7", 8'h09, 0);
        cal_expect("R7", 8'h0A, 0);
        cal_expect("R7", 8'h0B, 0);
        cal_expect("R7", 8'h0C, 8'h80);

        // R6: carry sticks, spare bits stored
        cal_set(8'h0C, 8'h00); snap_take(); cal_expect("R6", 8'h0C, 8'h80);
        cal_set(8'h0C, 8'h3E); snap_take(); cal_expect("R6", 8'h0C, 8'hBE);

        // R8: halt blocks ticks
        cal_set(8'h0C, 8'h40); cal_set(8'h08, 8'd10);
        pulse_tick(3); snap_take(); cal_expect("R8", 8'h08, 10);
        cal_set(8'h0C, 8'h00);
        pulse_tick(2); snap_take(); cal_expect("R7", 8'h08, 12);

        // R7: calendar write in a tick cycle drops the tick
        wr(16'h4000, 8'h08);
        tick = 1'b1; wr(16'hA000, 8'd30); tick = 1'b0;
        snap_take(); cal_expect("R7", 8'h08, 30);

        // R9: only a 0 then 1 sequence copies; stray values ignored
        cal_set(8'h08, 8'd40);
        wr(16'h6000, 8'h01); cal_expect("R9", 8'h08, 30);
        wr(16'h6000, 8'h05); wr(16'h6000, 8'h01); cal_expect("R9", 8'h08, 30);
        wr(16'h6000, 8'h00); wr(16'h6000, 8'h07); wr(16'h6000, 8'h01);
        cal_expect("R9", 8'h08, 40);

        // R10: undefined selector and disabled window read zero
        cal_expect("R10", 8'h0D, 0);
        wr(16'h4000, 8'h08);
        wr(16'h0000, 8'h00);
        bus_addr = 16'hA000; #1;
        check("R10", win_rdata, 0);
        check("R10", win_use_ram, 0);
        @(posedge clk); #1;

        repeat (4) @(posedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule